// File: doc/BRIEF.md
# ADC Start Sequencer with Cascaded Interval Timers

This block decides when an analog-to-digital converter begins a conversion. Two chained down-counters, clocked by a base tick derived from the system clock, set the interval between starts. The interval equals the product of their two reload values, N1 × N0 ticks. In periodic mode the pair runs freely and issues a start at the end of every interval, without any involvement from the host. In software mode and in external mode the same pair works as a one-shot delay. After an accepted trigger, exactly one start follows once N1 × N0 ticks have passed. This delay gives the input multiplexer time to settle after a channel switch.

Every start is a single-clock pulse. It also raises a hold output that keeps the sample-and-hold stage in hold for the conversion time. Triggers that arrive during hold are dropped. A periodic setting whose interval is shorter than the conversion time is rejected and flagged. A third, independent down-counter runs on the same tick for general use. Registers are loaded through plain write strobes; bus decoding lies outside the block.

Top module: `adc_start_sequencer`

## Requirements
- R1: In periodic mode (mode code 0), with enable and arm set and a valid setting, `start_pulse` rises N1·N0·TICK_DIV clocks after the clock edge that captured the command write. It then repeats every N1·N0·TICK_DIV clocks.
- R2: `cfg_bad` is 1 whenever either reload value is 0. In periodic mode it is also 1 when N1·N0 < CONV_TICKS or when either reload equals 2. While `cfg_bad` is 1, no start is issued.
- R3: In software mode (mode code 1), a 0-to-1 change of `sw_trig` is accepted on the next clock edge. One start follows N1·N0·TICK_DIV clocks after that edge. Keeping `sw_trig` high yields no further start.
- R4: In external mode (mode code 2), `ext_start` passes through a two-flop synchronizer. A rising level is accepted on the third clock edge after the pin goes high. One start follows N1·N0·TICK_DIV clocks after that edge.
- R5: A trigger that arrives while `hold` is 1 is ignored. A trigger that arrives during a pending delay restarts the delay from its own accepting edge.
- R6: The command word has enable at bit 0 and arm at bit 1. Starts are issued only while both bits are 1. Clearing either bit stops periodic starts and cancels a pending one-shot.
- R7: `start_pulse` is 1 for exactly one clock. `hold` rises together with it and stays 1 for CONV_TICKS·TICK_DIV clocks.
- R8: `sw_trig` has no effect in external mode, and `ext_start` has no effect in software mode. Mode code 3 issues no starts.
- R9: Writing value V through `user_wr` sets `user_count` to V. The count then falls by one every TICK_DIV clocks and stops at 0. `user_done` is 1 exactly when the count is 0.
- R10: After reset, `start_pulse` and `hold` are 0, `cfg_bad` is 1 (both reloads are 0), `user_count` is 0 and `user_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_data | input | 2 | Command word: bit 0 enable, bit 1 arm |
| mode_wr | input | 1 | Write strobe for the start mode |
| mode_data | input | 2 | Mode: 0 periodic, 1 software, 2 external, 3 off |
| reload_data | input | CNT_W | Value for the reload and user-counter writes |
| reload0_wr | input | 1 | Loads N0 (second counter of the chain) |
| reload1_wr | input | 1 | Loads N1 (first counter, divides the tick) |
| user_wr | input | 1 | Loads the general-purpose counter |
| sw_trig | input | 1 | Software trigger level; its rising change counts |
| ext_start | input | 1 | Asynchronous external trigger pin |
| start_pulse | output | 1 | One-clock conversion start |
| hold | output | 1 | Sample-and-hold hold command during conversion |
| cfg_bad | output | 1 | Current reload setting rejected |
| user_count | output | CNT_W | Value of the general-purpose counter |
| user_done | output | 1 | General-purpose counter has reached 0 |

## Verification
All timing is counted from a single clock edge. For periodic mode, the edge that captures the command write is the reference, and the first start is due N1·N0·TICK_DIV clocks after it. For software triggers, the reference is the edge after `sw_trig` rises. For external triggers, it is the third edge after `ext_start` rises. `hold` is then due to fall CONV_TICKS·TICK_DIV clocks after the start. The user counter is due to drop every TICK_DIV clocks after its load edge. The bench drives inputs and samples outputs on the falling clock edge and keeps a count of rising edges. It then compares each observed start edge, and the length of each hold window, against these arithmetic offsets. It runs them over sweeps of reload pairs that include both rejected and boundary settings.

// File: rtl/sseq_pkg.sv
// Shared types for the ADC start sequencer.
// Assumes: the mode code is two bits wide; the command word's bit positions are fixed.
package sseq_pkg;
    typedef enum logic [1:0] {
        MODE_PERIODIC = 2'd0,
        MODE_SOFT     = 2'd1,
        MODE_EXT      = 2'd2,
        MODE_OFF      = 2'd3
    } start_mode_e;

    localparam int CMD_EN_BIT  = 0;
    localparam int CMD_ARM_BIT = 1;
endpackage

// File: rtl/sseq_prescaler.sv
// Base tick generator. While run is high it emits one tick every DIV clocks.
// clear or a low run returns the phase to zero, so the first tick comes DIV clocks after a restart.
// Assumes DIV >= 1.
module sseq_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Phase counter: free-running while active, parked at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + PW'(1);
        end
    end

    assign tick = run && !clear && (phase == LAST);

    generate
        if (DIV > 1) begin : g_tick_chk
            // R1: ticks are spaced, never back to back, when DIV exceeds one.
            assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/sseq_cascade.sv
// Two chained down-counters. The first divides the tick by N1; each of its
// wraps decrements the second, which divides by N0. wrap is high in the tick
// that ends an N1*N0 interval. restart or a low go reloads both counters.
// Assumes the reloads are non-zero while go is high (the caller rejects zeros).
module sseq_cascade #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] n1,
    input  logic [CNT_W-1:0] n0,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] div_a;
    logic [CNT_W-1:0] div_b;

    assign wrap = go && tick && !restart && (div_a == ONE) && (div_b == ONE);

    // Counter pair: reload while idle or restarting; otherwise count down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !go) begin
            div_a <= n1;
            div_b <= n0;
        end else if (tick) begin
            if (div_a == ONE) begin
                div_a <= n1;
                div_b <= (div_b == ONE) ? n0 : div_b - ONE;
            end else begin
                div_a <= div_a - ONE;
            end
        end
    end

    // R1: after an interval ends, both counters start over from their reloads.
    assert_wrap_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (div_a == $past(n1)) && (div_b == $past(n0)));
endmodule

// File: rtl/sseq_edge_sync.sv
// Rising-edge detector with an optional synchronizer in front.
// STAGES = 0 takes din as already synchronous; STAGES >= 2 adds that many flops.
// rise is high for one clock after the (synchronized) level goes from 0 to 1.
module sseq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic level;
    logic level_q;

    generate
        if (STAGES == 0) begin : g_direct
            assign level = din;
        end else begin : g_sync
            logic [STAGES-1:0] chain;
            // Synchronizer chain: shift the pin value through STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain[0] <= din;
                    for (int i = 1; i < STAGES; i++) begin
                        chain[i] <= chain[i-1];
                    end
                end
            end
            assign level = chain[STAGES-1];
        end
    endgenerate

    // Previous-level flop for the edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level && !level_q;

    // R3: one level change gives a single event.
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sseq_user_counter.sv
// General-purpose down-counter on the base tick. A load sets the count and
// restarts the tick phase; the counter then steps down once per tick and stops at zero.
module sseq_user_counter #(
    parameter int CNT_W = 16,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    logic tick;

    sseq_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (count != '0),
        .clear (load),
        .tick  (tick)
    );

    // Count register: load wins, then one step down per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (load)   count <= value;
        else if (tick)   count <= count - CNT_W'(1);
    end

    assign done = (count == '0);

    // R9: without a load the count never rises.
    assert_user_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> count <= $past(count));
endmodule

// File: rtl/adc_start_sequencer.sv
// ADC start sequencer top. Holds the command, mode and reload registers and
// chooses between periodic and one-shot operation. It drives the cascaded
// interval counters and times the conversion hold window.
// Assumes CONV_TICKS >= 2, so that starts cannot fall on consecutive clocks.
module adc_start_sequencer
    import sseq_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TICK_DIV    = 4,
    parameter int CONV_TICKS  = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [1:0]       cmd_data,
    input  logic             mode_wr,
    input  logic [1:0]       mode_data,
    input  logic [CNT_W-1:0] reload_data,
    input  logic             reload0_wr,
    input  logic             reload1_wr,
    input  logic             user_wr,
    input  logic             sw_trig,
    input  logic             ext_start,
    output logic             start_pulse,
    output logic             hold,
    output logic             cfg_bad,
    output logic [CNT_W-1:0] user_count,
    output logic             user_done
);
    localparam int CONV_CLKS = CONV_TICKS * TICK_DIV;
    localparam int HW        = $clog2(CONV_CLKS + 1);
    localparam int PROD_W    = 2 * CNT_W;
    localparam logic [PROD_W-1:0] MIN_PROD = PROD_W'(CONV_TICKS);
    localparam logic [CNT_W-1:0]  BANNED   = CNT_W'(2);

    logic             en_q, arm_q;
    start_mode_e      mode_q;
    logic [CNT_W-1:0] n0_q, n1_q;
    logic [HW-1:0]    hold_cnt;
    logic             os_active;
    logic             sw_rise, ext_rise;
    logic             tick, fire;

    // Control registers, written through their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            arm_q  <= 1'b0;
            mode_q <= MODE_PERIODIC;
            n0_q   <= '0;
            n1_q   <= '0;
        end else begin
            if (cmd_wr) begin
                en_q  <= cmd_data[CMD_EN_BIT];
                arm_q <= cmd_data[CMD_ARM_BIT];
            end
            if (mode_wr)    mode_q <= start_mode_e'(mode_data);
            if (reload0_wr) n0_q   <= reload_data;
            if (reload1_wr) n1_q   <= reload_data;
        end
    end

    // Setting checks: zero reloads always; periodic adds the minimum interval and the banned value.
    logic [PROD_W-1:0] interval;
    logic              zero_bad, per_bad;
    assign interval = PROD_W'(n1_q) * PROD_W'(n0_q);
    assign zero_bad = (n0_q == '0) || (n1_q == '0);
    assign per_bad  = (interval < MIN_PROD) || (n0_q == BANNED) || (n1_q == BANNED);
    assign cfg_bad  = zero_bad || ((mode_q == MODE_PERIODIC) && per_bad);

    // Trigger conditioning: software level is synchronous, the pin is synchronized.
    sseq_edge_sync #(.STAGES(0)) u_sw_edge (
        .clk (clk), .rst_n (rst_n), .din (sw_trig), .rise (sw_rise)
    );
    sseq_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_edge (
        .clk (clk), .rst_n (rst_n), .din (ext_start), .rise (ext_rise)
    );

    logic ready, oneshot_mode, trig, accept, go;
    assign ready        = en_q && arm_q && !cfg_bad;
    assign oneshot_mode = (mode_q == MODE_SOFT) || (mode_q == MODE_EXT);
    assign trig         = ((mode_q == MODE_SOFT) && sw_rise) || ((mode_q == MODE_EXT) && ext_rise);
    assign accept       = ready && oneshot_mode && trig && (hold_cnt == '0);
    assign go           = ready && ((mode_q == MODE_PERIODIC) || os_active);

    // One-shot state: set by an accepted trigger, cleared by its start or by losing readiness.
    always_ff @(posedge clk) begin
        if (!rst_n || !ready || !oneshot_mode) os_active <= 1'b0;
        else if (accept)                       os_active <= 1'b1;
        else if (fire)                         os_active <= 1'b0;
    end

    sseq_prescaler #(.DIV(TICK_DIV)) u_tick (
        .clk (clk), .rst_n (rst_n), .run (go), .clear (accept), .tick (tick)
    );

    sseq_cascade #(.CNT_W(CNT_W)) u_cascade (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .restart (accept),
        .tick    (tick),
        .n1      (n1_q),
        .n0      (n0_q),
        .wrap    (fire)
    );

    // Start pulse register: one clock per interval end.
    always_ff @(posedge clk) begin
        if (!rst_n) start_pulse <= 1'b0;
        else        start_pulse <= fire;
    end

    // Conversion window: loaded by a start, counts down in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)                hold_cnt <= '0;
        else if (fire)             hold_cnt <= HW'(CONV_CLKS);
        else if (hold_cnt != '0)   hold_cnt <= hold_cnt - HW'(1);
    end

    assign hold = (hold_cnt != '0);

    sseq_user_counter #(.CNT_W(CNT_W), .DIV(TICK_DIV)) u_user (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (user_wr),
        .value (reload_data),
        .count (user_count),
        .done  (user_done)
    );

    // R6: a start only follows a cycle with enable and arm both set.
    assert_start_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(en_q && arm_q));
    // R2: no start comes out of a rejected setting.
    assert_start_cfg_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(!cfg_bad));
    // R7: the start is a single clock wide.
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    // R7: hold is raised together with every start.
    assert_hold_with_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> hold);
    // R5: a new start never cuts into a running conversion window.
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> ($past(hold_cnt) <= HW'(1)));
endmodule

// File: tb/adc_start_sequencer_bench.sv
`timescale 1ns/1ps
module adc_start_sequencer_bench;
    localparam int CW   = 8;
    localparam int DIV  = 2;
    localparam int CONV = 30;
    localparam int CONV_CLKS = CONV * DIV;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cmd_wr = 0, mode_wr = 0, reload0_wr = 0, reload1_wr = 0, user_wr = 0;
    logic [1:0]    cmd_data = '0, mode_data = '0;
    logic [CW-1:0] reload_data = '0;
    logic          sw_trig = 0, ext_start = 0;
    logic          start_pulse, hold, cfg_bad, user_done;
    logic [CW-1:0] user_count;

    adc_start_sequencer #(.CNT_W(CW), .TICK_DIV(DIV), .CONV_TICKS(CONV), .SYNC_STAGES(2))
    u_adc_start_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .mode_wr(mode_wr), .mode_data(mode_data), .reload_data(reload_data),
        .reload0_wr(reload0_wr), .reload1_wr(reload1_wr), .user_wr(user_wr),
        .sw_trig(sw_trig), .ext_start(ext_start), .start_pulse(start_pulse),
        .hold(hold), .cfg_bad(cfg_bad), .user_count(user_count), .user_done(user_done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_cmd(input bit en, input bit arm);
        @(negedge clk); cmd_data = {arm, en}; cmd_wr = 1'b1;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic write_mode(input int m);
        @(negedge clk); mode_data = 2'(m); mode_wr = 1'b1;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic write_reloads(input int n1, input int n0);
        @(negedge clk); reload_data = CW'(n1); reload1_wr = 1'b1;
        @(negedge clk); reload1_wr = 1'b0; reload_data = CW'(n0); reload0_wr = 1'b1;
        @(negedge clk); reload0_wr = 1'b0;
    endtask

    // Waits up to limit falling edges for a start; returns its edge index or -1.
    task automatic wait_start(input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (start_pulse) begin
                at = cyc;
                return;
            end
        end
    endtask

    task automatic setup(input int mode, input int n1, input int n0);
        write_cmd(1'b0, 1'b0);
        write_reloads(n1, n0);
        write_mode(mode);
        write_cmd(1'b1, 1'b1);
    endtask

    // Software trigger: rising change driven now; returns the accepting edge.
    task automatic sw_rise(output int e);
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); e = cyc;
    endtask

    task automatic ext_pulse(output int e);
        int c;
        @(negedge clk); c = cyc; ext_start = 1'b1;
        @(negedge clk); ext_start = 1'b0;
        e = c + 3;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin : main
        int s, s2, e, e2, w, p, hc;
        bit bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check_eq("R10", "start_pulse", start_pulse, 0);
        check_eq("R10", "hold", hold, 0);
        check_eq("R10", "cfg_bad", cfg_bad, 1);
        check_eq("R10", "user_count", user_count, 0);
        check_eq("R10", "user_done", user_done, 1);

        // R1 / R2 / R7: periodic sweep over reload pairs
        for (int n1 = 1; n1 <= 5; n1++) begin
            for (int n0 = 5; n0 <= 14; n0++) begin
                bad = (n1 * n0 < CONV) || (n1 == 2) || (n0 == 2);
                p = n1 * n0 * DIV;
                write_cmd(1'b0, 1'b0);
                write_reloads(n1, n0);
                write_mode(0);
                check_eq("R2", $sformatf("cfg_bad n1=%0d n0=%0d", n1, n0), cfg_bad, int'(bad));
                write_cmd(1'b1, 1'b1);
                w = cyc;
                if (bad) begin
                    wait_start(120, s);
                    check_eq("R2", "start from rejected setting", s, -1);
                end else begin
                    wait_start(p + 4, s);
                    check_eq("R1", $sformatf("first start offset n1=%0d n0=%0d", n1, n0), s - w, p);
                    hc = 0;
                    for (int k = 0; k < CONV_CLKS; k++) begin
                        if (k > 0) @(negedge clk);
                        if (hold) hc++;
                        if (k == 1) check_eq("R7", "pulse width", start_pulse, 0);
                    end
                    check_eq("R7", "hold length", hc, CONV_CLKS);
                    @(negedge clk);
                    if (p == CONV_CLKS) begin
                        s2 = start_pulse ? cyc : -1;
                    end else begin
                        check_eq("R7", "hold released", hold, 0);
                        wait_start(p, s2);
                    end
                    check_eq("R1", "period", s2 - s, p);
                end
            end
        end
        // R2: banned value 2 in the second counter
        write_cmd(1'b0, 1'b0); write_reloads(15, 2); write_mode(0);
        check_eq("R2", "cfg_bad n0=2", cfg_bad, 1);

        // R6: disabling stops periodic starts
        setup(0, 3, 10);
        wait_start(70, s);
        check_eq("R6", "running before disable", int'(s >= 0), 1);
        write_cmd(1'b0, 1'b1);
        wait_start(150, s);
        check_eq("R6", "start after disable", s, -1);

        // R3: software one-shot sweep, level held high gives one start
        for (int n1 = 1; n1 <= 3; n1++) begin
            for (int n0 = 1; n0 <= 3; n0++) begin
                setup(1, n1, n0);
                check_eq("R3", "cfg_bad soft", cfg_bad, 0);
                sw_rise(e);
                wait_start(n1 * n0 * DIV + 4, s);
                check_eq("R3", $sformatf("soft delay n1=%0d n0=%0d", n1, n0), s - e, n1 * n0 * DIV);
                wait_start(CONV_CLKS + 20, s2);
                check_eq("R3", "no repeat while held high", s2, -1);
                sw_trig = 1'b0;
            end
        end

        // R5: trigger during hold ignored, later trigger accepted
        setup(1, 2, 3);
        p = 12;
        sw_rise(e);
        wait_start(p + 4, s);
        @(negedge clk); sw_trig = 1'b0;
        repeat (8) @(negedge clk);
        sw_trig = 1'b1;
        wait_start(CONV_CLKS, s2);
        check_eq("R5", "trigger in hold", s2, -1);
        @(negedge clk); sw_trig = 1'b0;
        sw_rise(e);
        wait_start(p + 4, s);
        check_eq("R5", "trigger after hold", s - e, p);
        @(negedge clk); sw_trig = 1'b0;
        wait_start(CONV_CLKS + 4, s);
        // R5: retrigger during the delay restarts it
        sw_rise(e);
        repeat (2) @(negedge clk);
        sw_trig = 1'b0;
        sw_rise(e2);
        wait_start(p + 10, s);
        check_eq("R5", "retrigger restarts delay", s - e2, p);
        @(negedge clk); sw_trig = 1'b0;
        wait_start(CONV_CLKS + 4, s);

        // R6: pending one-shot cancelled by clearing arm
        sw_rise(e);
        write_cmd(1'b1, 1'b0);
        wait_start(40, s);
        check_eq("R6", "cancelled one-shot", s, -1);
        sw_trig = 1'b0;

        // R4: external trigger sweep
        for (int n0 = 1; n0 <= 4; n0++) begin
            setup(2, 2, n0);
            ext_pulse(e);
            wait_start(2 * n0 * DIV + 6, s);
            check_eq("R4", $sformatf("external delay n0=%0d", n0), s - e, 2 * n0 * DIV);
            wait_start(CONV_CLKS + 4, s);
        end

        // R8: software trigger ignored in external mode
        setup(2, 2, 3);
        sw_rise(e);
        wait_start(40, s);
        check_eq("R8", "sw_trig in external mode", s, -1);
        sw_trig = 1'b0;
        // R8: external pin ignored in software mode
        setup(1, 2, 3);
        ext_pulse(e);
        wait_start(40, s);
        check_eq("R8", "ext_start in software mode", s, -1);
        // R8: mode 3 issues nothing
        setup(3, 2, 3);
        ext_pulse(e);
        sw_rise(e);
        wait_start(40, s);
        check_eq("R8", "mode 3", s, -1);
        sw_trig = 1'b0;
        // R6: external pin ignored with enable cleared
        write_mode(2);
        write_cmd(1'b0, 1'b1);
        ext_pulse(e);
        wait_start(40, s);
        check_eq("R6", "external with enable low", s, -1);

        // R2: zero reload rejected in software mode
        setup(1, 0, 3);
        check_eq("R2", "cfg_bad zero reload", cfg_bad, 1);
        @(negedge clk); sw_trig = 1'b0;
        sw_rise(e);
        wait_start(40, s);
        check_eq("R2", "trigger with zero reload", s, -1);
        sw_trig = 1'b0;

        // R9: user counter sweep
        for (int v = 1; v <= 6; v++) begin
            @(negedge clk); reload_data = CW'(v); user_wr = 1'b1;
            @(negedge clk); user_wr = 1'b0;
            w = cyc;
            check_eq("R9", "count after load", user_count, v);
            check_eq("R9", "done after load", user_done, 0);
            repeat (v * DIV - 1) @(negedge clk);
            check_eq("R9", "count one step before end", user_count, 1);
            @(negedge clk);
            check_eq("R9", $sformatf("count reaches zero v=%0d", v), user_count, 0);
            check_eq("R9", "done at zero", user_done, 1);
            repeat (5) @(negedge clk);
            check_eq("R9", "stays at zero", user_count, 0);
        end

        finish_run();
    end
endmodule